// File: doc/BRIEF.md
# Segment Descriptor Load Unit

This block models one segment register in protected mode. The register has two parts. The visible part is a 16-bit selector. The hidden part is a descriptor cache that holds a base, a limit and the attribute bits. A descriptor-table register, loaded by a write port, holds the table's base address and its 16-bit byte limit.

When a selector is written, the unit first checks that the whole 8-byte entry it names lies inside the table. It then fetches that entry over a request/valid read port. It unpacks the scattered base, limit and attribute fields and commits them to the hidden cache. The visible selector is updated in the same cycle.

Offsets are translated to linear addresses combinationally. Translation uses only the cached values and checks each offset against the cached limit, which is scaled by the granularity bit. If the table in memory changes after a load, nothing visible changes until the selector is written again.

Top module: `seg_shadow_unit`

## Requirements
- R1: After reset, busy, mem_req, fault_sel, fault_np and seg_valid are 0, sel_out is 0, and xl_fault is 1.
- R2: The selector is decoded as index = bits 15:3, table indicator = bit 2 and RPL = bits 1:0. A selector is rejected if its table indicator is 1, or if index*8+7 is greater than the table limit. An accepted write of a rejected selector sets fault_sel in the next cycle, starts no fetch, and leaves the cache and sel_out unchanged.
- R3: An in-range selector raises busy and mem_req in the cycle after the write. mem_addr equals table base + index*8 and stays stable. busy and mem_req remain high until the clock edge at which mem_valid is seen, and are low in the cycle after that edge.
- R4: On a fetch, the unit unpacks the descriptor word as follows:
  - base = {bits 63:56, bits 39:32, bits 31:16}
  - limit = {bits 51:48, bits 15:0}
  - type = bits 43:40
  - seg_s = bit 44, where 0 means a system descriptor and 1 means code or data
  - DPL = bits 46:45
  - present = bit 47
  - seg_avl = bit 52
  - seg_l = bit 53, where 1 means a 64-bit code segment
  - seg_db = bit 54
  - seg_g = bit 55
- R5: If the fetched descriptor has present bit 47 equal to 0, fault_np is set in the next cycle. The cache, seg_valid and sel_out keep their previous values.
- R6: The effective limit depends on seg_g. When seg_g is 1, it is {limit, 12'hFFF}. When seg_g is 0, it is the 20-bit limit zero-extended.
- R7: xl_linear equals the cached base plus xl_offset. xl_fault is 1 when xl_offset is greater than the effective limit, or when no descriptor has been committed.
- R8: After a commit, changes to the table in memory have no effect on the cache or the translation until the selector is written again.
- R9: A selector write while busy is high is ignored.
- R10: On a successful fetch, sel_out takes the full written selector value, RPL included, and seg_valid becomes 1. fault_sel and fault_np are cleared by the next accepted selector write.
- R11: A table-register write takes effect for the selector loads that follow it. With a limit of 0x47, indices 0 to 8 are accepted and index 9 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_wr | input | 1 | Write strobe for the table register |
| tbl_base_in | input | AW | New table base |
| tbl_limit_in | input | 16 | New table byte limit |
| sel_wr | input | 1 | Selector write strobe |
| sel_in | input | 16 | Selector value |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | AW | Descriptor byte address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 64 | Descriptor word |
| busy | output | 1 | Load in progress |
| fault_sel | output | 1 | Selector rejected |
| fault_np | output | 1 | Descriptor not present |
| sel_out | output | 16 | Visible selector |
| seg_valid | output | 1 | Cache holds a committed descriptor |
| seg_base | output | 32 | Cached base |
| seg_limit | output | 20 | Cached raw limit |
| seg_type | output | 4 | Cached type |
| seg_s | output | 1 | Code/data (1) or system (0) |
| seg_dpl | output | 2 | Cached DPL |
| seg_avl | output | 1 | Cached available bit |
| seg_l | output | 1 | 64-bit code segment |
| seg_db | output | 1 | Default size bit |
| seg_g | output | 1 | Granularity bit |
| xl_offset | input | 32 | Offset to translate |
| xl_linear | output | AW | Linear address |
| xl_fault | output | 1 | Limit fault |

## Verification
The bench builds the unit with AW = 36 and places the table base above bit 32, so that address arithmetic in the upper bits is checked. It uses eighteen descriptors with varied fields and three table limits (0x3B, 0x47, 0x7F). Every index from 0 to 17 is loaded under each limit, so the accept/reject boundary is crossed in every configuration, including the 9-entry case. For each committed descriptor, translation is probed at offset zero, at the effective limit and one past it, covering both granularity settings.

// File: rtl/seg_shadow_unit.sv
module seg_shadow_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_wr,
  input  logic [AW-1:0] tbl_base_in,
  input  logic [15:0]   tbl_limit_in,
  input  logic          sel_wr,
  input  logic [15:0]   sel_in,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [63:0]   mem_data,
  output logic          busy,
  output logic          fault_sel,
  output logic          fault_np,
  output logic [15:0]   sel_out,
  output logic          seg_valid,
  output logic [31:0]   seg_base,
  output logic [19:0]   seg_limit,
  output logic [3:0]    seg_type,
  output logic          seg_s,
  output logic [1:0]    seg_dpl,
  output logic          seg_avl,
  output logic          seg_l,
  output logic          seg_db,
  output logic          seg_g,
  input  logic [31:0]   xl_offset,
  output logic [AW-1:0] xl_linear,
  output logic          xl_fault
);

  logic [AW-1:0] tbl_base_q;
  logic [15:0]   tbl_limit_q;
  logic [15:0]   pend_sel;
  logic [AW-1:0] addr_q;

  logic accept, sel_ok, present;
  logic [31:0] d_base;
  logic [19:0] d_limit;
  logic [31:0] eff_limit;

  assign accept  = sel_wr && !busy;
  assign sel_ok  = !sel_in[2] && ({sel_in[15:3], 3'b111} <= tbl_limit_q);
  assign present = mem_data[47];
  assign d_base  = {mem_data[63:56], mem_data[39:32], mem_data[31:16]};
  assign d_limit = {mem_data[51:48], mem_data[15:0]};

  assign mem_req  = busy;
  assign mem_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base_q  <= '0;
      tbl_limit_q <= '0;
    end else if (tbl_wr) begin
      tbl_base_q  <= tbl_base_in;
      tbl_limit_q <= tbl_limit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fault_sel <= 1'b0;
      fault_np  <= 1'b0;
      pend_sel  <= '0;
      addr_q    <= '0;
    end else if (accept) begin
      fault_sel <= !sel_ok;
      fault_np  <= 1'b0;
      if (sel_ok) begin
        busy     <= 1'b1;
        pend_sel <= sel_in;
        addr_q   <= tbl_base_q + AW'({sel_in[15:3], 3'b000});
      end
    end else if (busy && mem_valid) begin
      busy     <= 1'b0;
      fault_np <= !present;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_out   <= '0;
      seg_valid <= 1'b0;
      seg_base  <= '0;
      seg_limit <= '0;
      seg_type  <= '0;
      seg_s     <= 1'b0;
      seg_dpl   <= '0;
      seg_avl   <= 1'b0;
      seg_l     <= 1'b0;
      seg_db    <= 1'b0;
      seg_g     <= 1'b0;
    end else if (busy && mem_valid && present) begin
      sel_out   <= pend_sel;
      seg_valid <= 1'b1;
      seg_base  <= d_base;
      seg_limit <= d_limit;
      seg_type  <= mem_data[43:40];
      seg_s     <= mem_data[44];
      seg_dpl   <= mem_data[46:45];
      seg_avl   <= mem_data[52];
      seg_l     <= mem_data[53];
      seg_db    <= mem_data[54];
      seg_g     <= mem_data[55];
    end
  end

  assign eff_limit = seg_g ? {seg_limit, 12'hFFF} : {12'h000, seg_limit};
  assign xl_fault  = !seg_valid || (xl_offset > eff_limit);
  assign xl_linear = AW'(seg_base) + AW'(xl_offset);

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && !busy && (sel_in[2] || ({sel_in[15:3], 3'b111} > tbl_limit_q)))
      |=> (fault_sel && !busy && $stable(sel_out)));

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |=> (busy && $stable(mem_addr)));

  p_busy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid) |=> !busy);

  p_absent_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid && !mem_data[47])
      |=> (fault_np && $stable(seg_base) && $stable(seg_limit) && $stable(sel_out)));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sel_wr && !mem_valid) |=> (busy && $stable(mem_addr) && !fault_sel));

  p_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_valid && mem_data[47]) |=> (seg_valid && (sel_out == $past(pend_sel))));

  p_cache_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && mem_valid) |=> ($stable(seg_base) && $stable(seg_limit) && $stable(seg_g)));

endmodule

// File: tb/test_seg_shadow_unit.sv
module test_seg_shadow_unit;
  localparam int AW = 36;
  localparam logic [AW-1:0] TB = 36'h8_0000_1000;
  localparam int NE = 18;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic          tbl_wr = 0;
  logic [AW-1:0] tbl_base_in = '0;
  logic [15:0]   tbl_limit_in = '0;
  logic          sel_wr = 0;
  logic [15:0]   sel_in = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 0;
  logic [63:0]   mem_data = '0;
  logic          busy, fault_sel, fault_np, seg_valid;
  logic [15:0]   sel_out;
  logic [31:0]   seg_base;
  logic [19:0]   seg_limit;
  logic [3:0]    seg_type;
  logic          seg_s, seg_avl, seg_l, seg_db, seg_g;
  logic [1:0]    seg_dpl;
  logic [31:0]   xl_offset = '0;
  logic [AW-1:0] xl_linear;
  logic          xl_fault;

  seg_shadow_unit #(.AW(AW)) i_seg_shadow_unit (
    .clk(clk), .rst_n(rst_n), .tbl_wr(tbl_wr), .tbl_base_in(tbl_base_in),
    .tbl_limit_in(tbl_limit_in), .sel_wr(sel_wr), .sel_in(sel_in),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .busy(busy), .fault_sel(fault_sel), .fault_np(fault_np), .sel_out(sel_out),
    .seg_valid(seg_valid), .seg_base(seg_base), .seg_limit(seg_limit), .seg_type(seg_type),
    .seg_s(seg_s), .seg_dpl(seg_dpl), .seg_avl(seg_avl), .seg_l(seg_l), .seg_db(seg_db),
    .seg_g(seg_g), .xl_offset(xl_offset), .xl_linear(xl_linear), .xl_fault(xl_fault)
  );

  int total = 0;
  int bad = 0;
  logic [63:0] mem [NE];
  logic        exp_valid = 0;
  logic [63:0] exp_desc = '0;
  logic [15:0] exp_sel = '0;
  logic [15:0] cur_limit = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int i, input int salt);
    logic [31:0] b;
    logic [19:0] lm;
    logic p, g;
    b  = {8'(i * 17 + salt), 8'(i * 3 + 1), 16'(i * 4660 + salt)};
    lm = 20'(i * 12345 + 7 + salt);
    p  = (i % 5) != 4;
    g  = (i % 4) >= 2;
    return {b[31:24], g, 1'(i >> 3), 1'(i >> 2), 1'(i >> 1), lm[19:16],
            p, 2'(i), 1'(i), 4'(i + salt), b[23:16], b[15:0], lm[15:0]};
  endfunction

  task automatic check_cache(input string ctx);
    logic [31:0] eb, eff;
    logic [19:0] el;
    chk(seg_valid == exp_valid, {"R10 seg_valid ", ctx}, 64'(seg_valid), 64'(exp_valid));
    chk(sel_out == exp_sel, {"R10 sel_out ", ctx}, 64'(sel_out), 64'(exp_sel));
    if (!exp_valid) begin
      xl_offset = 32'h0;
      #1;
      chk(xl_fault == 1'b1, {"R7 no cache ", ctx}, 64'(xl_fault), 64'd1);
      return;
    end
    eb = {exp_desc[63:56], exp_desc[39:32], exp_desc[31:16]};
    el = {exp_desc[51:48], exp_desc[15:0]};
    chk(seg_base == eb, {"R4 base ", ctx}, 64'(seg_base), 64'(eb));
    chk(seg_limit == el, {"R4 limit ", ctx}, 64'(seg_limit), 64'(el));
    chk({seg_g, seg_db, seg_l, seg_avl, seg_dpl, seg_s, seg_type} ==
        {exp_desc[55:52], exp_desc[46:44], exp_desc[43:40]},
        {"R4 attrs ", ctx},
        64'({seg_g, seg_db, seg_l, seg_avl, seg_dpl, seg_s, seg_type}),
        64'({exp_desc[55:52], exp_desc[46:44], exp_desc[43:40]}));
    eff = exp_desc[55] ? {el, 12'hFFF} : {12'h0, el};
    xl_offset = 32'h0;
    #1;
    chk(!xl_fault && xl_linear == AW'(eb), {"R7 off0 ", ctx}, 64'(xl_linear), 64'(eb));
    xl_offset = eff;
    #1;
    chk(!xl_fault && xl_linear == AW'(eb) + AW'(eff), {"R6 at limit ", ctx},
        64'(xl_linear), 64'(AW'(eb) + AW'(eff)));
    if (eff != 32'hFFFF_FFFF) begin
      xl_offset = eff + 1;
      #1;
      chk(xl_fault == 1'b1, {"R6 past limit ", ctx}, 64'(xl_fault), 64'd1);
    end
  endtask

  task automatic set_table(input logic [15:0] lim);
    @(negedge clk);
    tbl_wr = 1; tbl_base_in = TB; tbl_limit_in = lim;
    @(negedge clk);
    tbl_wr = 0;
    cur_limit = lim;
  endtask

  task automatic load(input logic [15:0] s, input int lat, input bit poke, input string ctx);
    int idx;
    bit ok;
    logic [63:0] d;
    idx = int'(s[15:3]);
    ok = !s[2] && ({s[15:3], 3'b111} <= cur_limit);
    @(negedge clk);
    sel_wr = 1; sel_in = s;
    @(negedge clk);
    sel_wr = 0;
    chk(fault_sel == !ok, {"R2 fault_sel ", ctx}, 64'(fault_sel), 64'(!ok));
    chk(busy == ok && mem_req == ok, {"R3 busy ", ctx}, 64'(busy), 64'(ok));
    if (!ok) begin
      check_cache(ctx);
      return;
    end
    chk(mem_addr == TB + AW'(idx * 8), {"R3 addr ", ctx}, 64'(mem_addr), 64'(TB + AW'(idx * 8)));
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin sel_wr = 1; sel_in = s ^ 16'h0008; end
      @(negedge clk);
      sel_wr = 0;
      chk(busy && mem_addr == TB + AW'(idx * 8), {"R9 hold ", ctx}, 64'(mem_addr), 64'(TB + AW'(idx * 8)));
    end
    d = (idx < NE) ? mem[idx] : 64'h0;
    mem_valid = 1; mem_data = d;
    @(negedge clk);
    mem_valid = 0; mem_data = '0;
    chk(!busy && !mem_req, {"R3 done ", ctx}, 64'(busy), 64'd0);
    chk(fault_np == !d[47], {"R5 fault_np ", ctx}, 64'(fault_np), 64'(!d[47]));
    if (d[47]) begin
      exp_valid = 1; exp_desc = d; exp_sel = s;
    end
    check_cache(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lims [3];
    lims[0] = 16'h003B; lims[1] = 16'h0047; lims[2] = 16'h007F;
    for (int i = 0; i < NE; i++) mem[i] = mk(i, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !fault_sel && !fault_np && !seg_valid && sel_out == 0,
        "R1 reset", 64'({busy, mem_req, fault_sel, fault_np, seg_valid}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check_cache("R1 post reset");

    for (int c = 0; c < 3; c++) begin
      set_table(lims[c]);
      for (int i = 0; i < NE; i++)
        load(16'({i[12:0], 3'b000}) | 16'(i % 4), 1 + (i % 3), 1'b0, $sformatf("R11 lim=%h idx=%0d", lims[c], i));
      for (int i = 0; i < 3; i++)
        load(16'({i[12:0], 3'b100}), 1, 1'b0, $sformatf("R2 ti idx=%0d", i));
    end

    set_table(16'h0047);
    load(16'h0043, 2, 1'b1, "R9 busy write");
    load(16'h0018, 1, 1'b0, "R8 load");
    mem[3] = mk(3, 5);
    repeat (4) @(negedge clk);
    check_cache("R8 after table edit");
    load(16'h0018, 1, 1'b0, "R8 reload");
    chk(seg_base == {mem[3][63:56], mem[3][39:32], mem[3][31:16]}, "R8 new base",
        64'(seg_base), 64'({mem[3][63:56], mem[3][39:32], mem[3][31:16]}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule